// File: doc/BRIEF.md
# Mode Banked Register File

This block is the general register file of a 32-bit processor core whose privilege modes each see a partly private set of registers. Software always names registers by an architectural index from 0 to 15; the block turns that index, together with the current privilege mode, into one of 31 physical storage slots. Two read ports return data combinationally and one write port stores on the rising clock edge. A separate port reads and writes the saved status word that belongs to the current exception mode.

The privilege mode is held in a register inside the block and is loaded from a 5-bit input when its load strobe is high. Each mode maps to one of six banks. The fast-interrupt bank has private copies of registers 8 to 12. Every bank has its own stack pointer (index 13) and link register (index 14). Every exception bank has its own saved status word. Registers 0 to 7 and 15 are common to all modes. The surrounding core handles decode, the live status word, exception entry and the program counter. For this block, index 15 is plain storage.

Top module: `mode_banked_regfile`

## Requirements
- R1: Architectural registers 0 to 7 and 15 have one physical copy; a value written in any mode reads back unchanged in every other mode.
- R2: Mode codes 10000 (user) and 11111 (system) select bank 0; in bank 0 the saved-status read returns zero and a saved-status write changes nothing.
- R3: Indices 13 and 14 each have six physical copies, one per bank (0 shared, 1 fast interrupt, 2 interrupt, 3 supervisor, 4 abort, 5 undefined); an access uses the copy of the current bank.
- R4: Indices 8 to 12 have two physical copies; bank 1 (mode code 10001) uses one, every other bank uses the other.
- R5: Banks 1 to 5 (mode codes 10001, 10010, 10011, 10111, 11011) each own a 32-bit saved status word, read and written through the saved-status port while that bank is current.
- R6: Loading the mode code that is already current leaves every register, every saved status word and the bank selection unchanged.
- R7: A mode code outside the seven listed ones selects bank 0.
- R8: Reset (synchronous, active high) clears every physical register and every saved status word and makes system mode (11111) current.
- R9: The mode register loads on the clock edge when mode_we is high; a register or saved-status write in that same cycle lands in the bank of the old mode, and reads after the edge see the new bank.
- R10: A read of the index being written in the same cycle returns the old value; the new value is visible after the clock edge.
- R11: The two read ports are independent; each returns the register named by its own index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Load mode_in into the mode register |
| mode_in | input | 5 | New privilege mode code |
| rd_a_idx | input | 4 | Architectural index, read port A |
| rd_a_data | output | 32 | Read data, port A (combinational) |
| rd_b_idx | input | 4 | Architectural index, read port B |
| rd_b_data | output | 32 | Read data, port B (combinational) |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Architectural index to write |
| wr_data | input | 32 | Register write data |
| sr_we | input | 1 | Saved status write strobe |
| sr_wr_data | input | 32 | Saved status write data |
| sr_rd_data | output | 32 | Saved status word of the current bank, zero in bank 0 |

## Verification
The hardest case to reach from the ports is a write in the same cycle as a mode change. Here the data must land in the bank that is being left. It only shows up later, after a second mode change returns to the first bank. The stimulus issues a stack-pointer write together with a load of abort mode. It checks that abort's copy is still zero, then goes back to interrupt mode and reads the written value there. Likewise, private copies are seeded in one exception mode and then read back after passing through other modes, an unknown code and a reload of the same code. This shows that no bank is disturbed by the others.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

  typedef enum logic [2:0] {
    BK_SHARED = 3'd0,
    BK_FAST   = 3'd1,
    BK_IRQ    = 3'd2,
    BK_SVC    = 3'd3,
    BK_ABT    = 3'd4,
    BK_UND    = 3'd5
  } bank_e;

  localparam int NUM_BANKS = 6;
  localparam int MODE_W    = 5;
  localparam int ARCH_W    = 4;

  localparam logic [MODE_W-1:0] MD_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MD_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MD_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MD_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MD_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MD_SYS = 5'b11111;

  // Physical slot layout
  localparam int LOW_CNT   = 8;               // indices 0..7
  localparam int R15_SLOT  = LOW_CNT;         // index 15
  localparam int HI_CNT    = 5;               // indices 8..12
  localparam int HI_COMMON = R15_SLOT + 1;
  localparam int HI_FAST   = HI_COMMON + HI_CNT;
  localparam int SP_BASE   = HI_FAST + HI_CNT;
  localparam int LR_BASE   = SP_BASE + NUM_BANKS;
  localparam int PHYS_N    = LR_BASE + NUM_BANKS;
  localparam int PHYS_W    = $clog2(PHYS_N);

endpackage

// File: rtl/mode_bank_decode.sv
module mode_bank_decode
  import mbrf_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output bank_e             bank
);

  always_comb begin
    case (mode)
      MD_FIQ:  bank = BK_FAST;
      MD_IRQ:  bank = BK_IRQ;
      MD_SVC:  bank = BK_SVC;
      MD_ABT:  bank = BK_ABT;
      MD_UND:  bank = BK_UND;
      default: bank = BK_SHARED; // user, system and unknown codes
    endcase
  end

endmodule

// File: rtl/phys_index_map.sv
module phys_index_map
  import mbrf_pkg::*;
(
  input  logic [ARCH_W-1:0] arch,
  input  bank_e             bank,
  output logic [PHYS_W-1:0] phys
);

  logic [PHYS_W-1:0] arch_ext;
  logic [PHYS_W-1:0] hi_off;
  logic [PHYS_W-1:0] bank_ext;

  assign arch_ext = PHYS_W'(arch);
  assign hi_off   = arch_ext - PHYS_W'(8);
  assign bank_ext = PHYS_W'(bank);

  always_comb begin
    if (arch < ARCH_W'(LOW_CNT)) begin
      phys = arch_ext;
    end else if (arch == 4'd15) begin
      phys = PHYS_W'(R15_SLOT);
    end else if (arch <= 4'd12) begin
      phys = (bank == BK_FAST) ? PHYS_W'(HI_FAST) + hi_off
                               : PHYS_W'(HI_COMMON) + hi_off;
    end else if (arch == 4'd13) begin
      phys = PHYS_W'(SP_BASE) + bank_ext;
    end else begin
      phys = PHYS_W'(LR_BASE) + bank_ext;
    end
  end

endmodule

// File: rtl/saved_status_bank.sv
module saved_status_bank
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  bank_e             bank,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int SLOTS = NUM_BANKS - 1;

  logic [DATA_W-1:0] word_q [SLOTS];
  logic [2:0]        slot;

  assign slot = 3'(bank) - 3'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) word_q[i] <= '0;
    end else if (we && bank != BK_SHARED) begin
      word_q[slot] <= wdata;
    end
  end

  assign rdata = (bank == BK_SHARED) ? '0 : word_q[slot];

endmodule

// File: rtl/mode_banked_regfile.sv
module mode_banked_regfile
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we,
  input  logic [4:0]        mode_in,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sr_we,
  input  logic [DATA_W-1:0] sr_wr_data,
  output logic [DATA_W-1:0] sr_rd_data
);

  localparam int NPORT = 3; // 0: write, 1: read A, 2: read B

  logic [MODE_W-1:0] cur_mode;
  bank_e             cur_bank;

  always_ff @(posedge clk) begin
    if (rst)          cur_mode <= MD_SYS;
    else if (mode_we) cur_mode <= mode_in;
  end

  mode_bank_decode u_dec (
    .mode (cur_mode),
    .bank (cur_bank)
  );

  logic [ARCH_W-1:0] port_arch [NPORT];
  logic [PHYS_W-1:0] port_phys [NPORT];

  assign port_arch[0] = wr_idx;
  assign port_arch[1] = rd_a_idx;
  assign port_arch[2] = rd_b_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    phys_index_map u_map (
      .arch (port_arch[p]),
      .bank (cur_bank),
      .phys (port_phys[p])
    );
  end

  logic [DATA_W-1:0] phys_q [PHYS_N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PHYS_N; i++) phys_q[i] <= '0;
    end else if (wr_en) begin
      phys_q[port_phys[0]] <= wr_data;
    end
  end

  assign rd_a_data = phys_q[port_phys[1]];
  assign rd_b_data = phys_q[port_phys[2]];

  saved_status_bank #(.DATA_W(DATA_W)) u_sr (
    .clk   (clk),
    .rst   (rst),
    .bank  (cur_bank),
    .we    (sr_we),
    .wdata (sr_wr_data),
    .rdata (sr_rd_data)
  );

endmodule

// File: rtl/mbrf_checker.sv
module mbrf_checker
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_we,
  input logic [4:0]        mode_in,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              sr_we,
  input logic [DATA_W-1:0] sr_rd_data,
  input logic [4:0]        cur_mode,
  input logic [2:0]        cur_bank
);

  logic known_mode;
  assign known_mode = (cur_mode == MD_USR) || (cur_mode == MD_FIQ) ||
                      (cur_mode == MD_IRQ) || (cur_mode == MD_SVC) ||
                      (cur_mode == MD_ABT) || (cur_mode == MD_UND) ||
                      (cur_mode == MD_SYS);

  a_r8_reset_sys: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cur_mode == MD_SYS);

  a_r2_no_saved_status: assert property (@(posedge clk) disable iff (rst)
    (cur_bank == 3'd0) |-> sr_rd_data == '0);

  a_r6_same_mode_stable: assert property (@(posedge clk) disable iff (rst)
    (mode_we && mode_in == cur_mode && !sr_we) |=> ($stable(cur_mode) && $stable(sr_rd_data)));

  a_r9_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !mode_we |=> $stable(cur_mode));

  a_r7_unknown_bank0: assert property (@(posedge clk) disable iff (rst)
    !known_mode |-> cur_bank == 3'd0);

  a_r10_write_visible: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mode_we) |=> ((rd_a_idx != $past(wr_idx)) || (rd_a_data == $past(wr_data))));

endmodule

bind mode_banked_regfile mbrf_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_we    (mode_we),
  .mode_in    (mode_in),
  .rd_a_idx   (rd_a_idx),
  .rd_a_data  (rd_a_data),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .sr_we      (sr_we),
  .sr_rd_data (sr_rd_data),
  .cur_mode   (cur_mode),
  .cur_bank   (cur_bank)
);

// File: tb/mode_banked_regfile_tb_top.sv
module mode_banked_regfile_tb_top;

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111, BAD = 5'b10101;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_we = 1'b0;
  logic [4:0]  mode_in = 5'b0;
  logic [3:0]  rd_a_idx = 4'd0, rd_b_idx = 4'd0, wr_idx = 4'd0;
  logic [31:0] rd_a_data, rd_b_data, sr_rd_data;
  logic        wr_en = 1'b0, sr_we = 1'b0;
  logic [31:0] wr_data = 32'h0, sr_wr_data = 32'h0;

  always #5 clk = ~clk;

  mode_banked_regfile dut_i (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_in(mode_in),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sr_we(sr_we), .sr_wr_data(sr_wr_data), .sr_rd_data(sr_rd_data)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // scoreboard queues: kind 0 = port A, 1 = port B, 2 = saved status
  int          q_kind[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];
  event        sample_ev;

  initial begin
    forever begin
      @(sample_ev);
      while (q_kind.size() > 0) begin
        int          k;
        logic [31:0] e, got;
        string       t;
        k = q_kind.pop_front();
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        got = (k == 0) ? rd_a_data : (k == 1) ? rd_b_data : sr_rd_data;
        compared++;
        if (got !== e) begin
          mismatched++;
          $display("FAIL %s: actual %h expected %h", t, got, e);
        end
      end
    end
  end

  task automatic sample();
    #1;
    ->sample_ev;
    #1;
  endtask

  task automatic exp_a(input logic [3:0] idx, input logic [31:0] e, input string t);
    rd_a_idx = idx;
    q_kind.push_back(0); q_exp.push_back(e); q_tag.push_back(t);
    sample();
  endtask

  task automatic exp_sr(input logic [31:0] e, input string t);
    q_kind.push_back(2); q_exp.push_back(e); q_tag.push_back(t);
    sample();
  endtask

  task automatic wr_reg(input logic [3:0] idx, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_sr(input logic [31:0] d);
    sr_we = 1'b1; sr_wr_data = d;
    @(posedge clk); @(negedge clk);
    sr_we = 1'b0;
  endtask

  task automatic set_mode(input logic [4:0] m);
    mode_we = 1'b1; mode_in = m;
    @(posedge clk); @(negedge clk);
    mode_we = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    exp_a(4'd0, 32'h0, "R8 reg0 after reset");
    exp_a(4'd13, 32'h0, "R8 sp after reset");
    exp_sr(32'h0, "R8 saved status after reset");

    // fill all indices in system mode
    for (int i = 0; i < 16; i++) wr_reg(4'(i), 32'h100 + 32'(i));
    exp_a(4'd13, 32'h10D, "R8 system mode uses bank 0 sp");

    // R2: user shares bank 0 with system
    set_mode(USR);
    exp_a(4'd13, 32'h10D, "R2 user sees system sp");
    exp_a(4'd9, 32'h109, "R2 user sees common r9");

    // fast interrupt mode
    set_mode(FIQ);
    exp_a(4'd0, 32'h100, "R1 r0 shared in fiq");
    exp_a(4'd7, 32'h107, "R1 r7 shared in fiq");
    exp_a(4'd15, 32'h10F, "R1 r15 shared in fiq");
    exp_a(4'd8, 32'h0, "R4 fiq private r8");
    exp_a(4'd12, 32'h0, "R4 fiq private r12");
    exp_a(4'd13, 32'h0, "R3 fiq sp");
    exp_a(4'd14, 32'h0, "R3 fiq lr");
    wr_reg(4'd8, 32'hF8);
    wr_reg(4'd13, 32'hF13);
    wr_sr(32'hAAAA);
    exp_sr(32'hAAAA, "R5 fiq saved status");

    // interrupt mode
    set_mode(IRQ);
    exp_a(4'd8, 32'h108, "R4 irq sees common r8");
    exp_a(4'd13, 32'h0, "R3 irq sp");
    exp_sr(32'h0, "R5 irq saved status clear");
    wr_reg(4'd13, 32'h1113);
    wr_sr(32'hBBBB);

    set_mode(SVC);
    exp_a(4'd13, 32'h0, "R3 svc sp");
    exp_sr(32'h0, "R5 svc saved status clear");

    set_mode(FIQ);
    exp_a(4'd8, 32'hF8, "R4 fiq r8 kept");
    exp_a(4'd13, 32'hF13, "R3 fiq sp kept");
    exp_sr(32'hAAAA, "R5 fiq saved status kept");

    // R6: reload same mode
    set_mode(FIQ);
    exp_a(4'd8, 32'hF8, "R6 r8 after same-mode reload");
    exp_a(4'd13, 32'hF13, "R6 sp after same-mode reload");
    exp_sr(32'hAAAA, "R6 saved status after same-mode reload");

    set_mode(IRQ);
    exp_a(4'd13, 32'h1113, "R3 irq sp kept");
    exp_sr(32'hBBBB, "R5 irq saved status kept");

    // R2: system has no saved status
    set_mode(SYS);
    exp_sr(32'h0, "R2 system saved status reads zero");
    wr_sr(32'h5555);
    exp_sr(32'h0, "R2 system saved status write ignored");
    exp_a(4'd13, 32'h10D, "R3 system sp kept");

    // R7: unknown code
    set_mode(BAD);
    exp_a(4'd13, 32'h10D, "R7 unknown code uses bank 0 sp");
    exp_a(4'd8, 32'h108, "R7 unknown code uses common r8");
    exp_sr(32'h0, "R7 unknown code saved status zero");
    wr_sr(32'h6666);
    set_mode(IRQ);
    exp_sr(32'hBBBB, "R7 unknown code write left irq status");

    // R9: write together with mode change goes to old bank
    mode_we = 1'b1; mode_in = ABT;
    wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h9999;
    sr_we = 1'b1; sr_wr_data = 32'hCCCC;
    @(posedge clk); @(negedge clk);
    mode_we = 1'b0; wr_en = 1'b0; sr_we = 1'b0;
    exp_a(4'd13, 32'h0, "R9 abort sp untouched");
    exp_sr(32'h0, "R9 abort saved status untouched");
    set_mode(IRQ);
    exp_a(4'd13, 32'h9999, "R9 write landed in irq sp");
    exp_sr(32'hCCCC, "R9 status write landed in irq");

    // R10: no write-through
    rd_a_idx = 4'd3;
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'hDEAD;
    exp_a(4'd3, 32'h103, "R10 same-cycle read returns old");
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    exp_a(4'd3, 32'hDEAD, "R10 new value after edge");

    // R11: two read ports
    rd_b_idx = 4'd14;
    q_kind.push_back(1); q_exp.push_back(32'h0); q_tag.push_back("R11 port B irq lr");
    exp_a(4'd1, 32'h101, "R11 port A r1");
    rd_b_idx = 4'd5;
    q_kind.push_back(1); q_exp.push_back(32'h105); q_tag.push_back("R11 port B r5");
    exp_a(4'd13, 32'h9999, "R11 port A irq sp");

    // undefined bank lr, separate from abort
    set_mode(UND);
    wr_reg(4'd14, 32'h77);
    exp_a(4'd14, 32'h77, "R3 und lr");
    set_mode(ABT);
    exp_a(4'd14, 32'h0, "R3 abort lr separate from und");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule